// File: doc/BRIEF.md
# Calendar Time Transfer Sequencer

This block sits on top of a serial register-transaction engine that talks to a real-time clock device. It turns three high-level operations into ordered sequences of single-register transactions: a startup presence probe, a full calendar read, and a full calendar set. The device keeps its time in packed BCD. The sequencer converts between BCD and binary and applies the calendar offsets, so the surrounding logic sees plain binary fields.

After reset the block probes the device on its own. It writes a known pattern to the seconds register and reads it back. On a match it clears the device's status register and reports the device present. On a mismatch it reports the device absent and stops. While it is idle, a read request first asks the device to freeze its running clock into its register file, then fetches the seven time registers. A set request writes the seven registers and then tells the device to load them into its running clock.

Each transaction is posted as a held request with an address, a direction, a command flag and write data. The engine answers with a one-cycle acknowledge, and for a register read the data comes with that acknowledge. A command carries no data phase: it is a write-type transaction whose address field holds the command code.

Top module: `rtc_time_seq`

## Requirements
- R1: After reset, the first transaction is a data write of 0x33 to the seconds address, and the second is a data read of the seconds address. `ready` stays low during both.
- R2: If the probe read returns 0x33, the next transaction writes 0x00 to the status address. After it completes, `probe_ok` is 1, `ready` is 1, and `probe_fail` stays 0.
- R3: If the probe read returns any other value, `probe_fail` goes to 1, `ready` stays 0, and no further transaction is issued, even when requests arrive.
- R4: A read first issues the snapshot command (`txn_cmd`=1, `txn_write`=1, address = snapshot code), before any register read.
- R5: After the snapshot, a read fetches the registers in this order: seconds, minutes, hours, day of month, month, weekday, year. Eight transactions in total.
- R6: Each fetched byte is decoded as packed BCD (tens in bits 7:4, units in bits 3:0) into binary. Seconds, minutes, hours, day of month and weekday are output unchanged after decoding.
- R7: On a read, `out_mon` is the decoded month minus 1, and `out_year` is the decoded year plus 100.
- R8: A set writes the same seven registers in the same order, each as packed BCD. The month is written as `in_mon`+1 and the year as `in_year` modulo 100.
- R9: A set ends with the commit command (`txn_cmd`=1, address = commit code), as its eighth and last transaction.
- R10: `done` is a one-cycle pulse at the end of each read or set, after which `ready` is 1. Requests made while an operation is running are ignored.
- R11: If `rd_req` and `wr_req` are both high in the same idle cycle, the read is performed and the set is dropped.
- R12: The output fields change only during a read. A set leaves them unchanged.
- R13: `txn_req` stays high, with stable address, direction, command flag and data, until `txn_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Start a calendar read (taken when ready) |
| wr_req | input | 1 | Start a calendar set (taken when ready) |
| in_sec | input | 7 | Seconds to set, binary |
| in_min | input | 7 | Minutes to set, binary |
| in_hour | input | 7 | Hours to set, binary |
| in_mday | input | 7 | Day of month to set, binary |
| in_mon | input | 7 | Month to set, 0-based binary |
| in_wday | input | 7 | Weekday to set, binary |
| in_year | input | 8 | Year to set; modulo 100 is stored |
| out_sec | output | 7 | Seconds read, binary |
| out_min | output | 7 | Minutes read, binary |
| out_hour | output | 7 | Hours read, binary |
| out_mday | output | 7 | Day of month read, binary |
| out_mon | output | 7 | Month read, 0-based |
| out_wday | output | 7 | Weekday read, binary |
| out_year | output | 8 | Year read, two-digit value plus 100 |
| txn_req | output | 1 | Transaction request, held until acknowledged |
| txn_write | output | 1 | 1 = write or command, 0 = register read |
| txn_cmd | output | 1 | 1 = command without data phase |
| txn_addr | output | 4 | Register address or command code |
| txn_wdata | output | 8 | Write data |
| txn_ack | input | 1 | One-cycle transaction completion |
| txn_rdata | input | 8 | Read data, valid with txn_ack |
| ready | output | 1 | Idle and able to take a request |
| probe_ok | output | 1 | Device found and status cleared |
| probe_fail | output | 1 | Device absent; block halted |
| done | output | 1 | One-cycle pulse at the end of a read or set |

## Verification
The assertions assume that the engine raises `txn_ack` only while `txn_req` is high, for a single cycle, and that it holds `txn_rdata` valid in that cycle. The bench's engine model meets this by design. It answers each request after a varying delay of zero to two cycles and drops the acknowledge on the following cycle. Device registers are only ever loaded with valid BCD values, so the decode never sees digits above nine. Request pulses are driven between clock edges and last exactly one cycle.

// File: rtl/rtc_time_seq.sv
module rtc_time_seq #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] A_SEC  = 4'd2,
  parameter logic [ADDR_W-1:0] A_MIN  = 4'd3,
  parameter logic [ADDR_W-1:0] A_HOUR = 4'd4,
  parameter logic [ADDR_W-1:0] A_MDAY = 4'd5,
  parameter logic [ADDR_W-1:0] A_MON  = 4'd6,
  parameter logic [ADDR_W-1:0] A_WDAY = 4'd7,
  parameter logic [ADDR_W-1:0] A_YEAR = 4'd8,
  parameter logic [ADDR_W-1:0] A_STAT = 4'd0,
  parameter logic [ADDR_W-1:0] CMD_SNAP   = 4'd14,
  parameter logic [ADDR_W-1:0] CMD_COMMIT = 4'd15,
  parameter logic [7:0] PROBE_PAT = 8'h33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [6:0]        in_sec,
  input  logic [6:0]        in_min,
  input  logic [6:0]        in_hour,
  input  logic [6:0]        in_mday,
  input  logic [6:0]        in_mon,
  input  logic [6:0]        in_wday,
  input  logic [7:0]        in_year,
  output logic [6:0]        out_sec,
  output logic [6:0]        out_min,
  output logic [6:0]        out_hour,
  output logic [6:0]        out_mday,
  output logic [6:0]        out_mon,
  output logic [6:0]        out_wday,
  output logic [7:0]        out_year,
  output logic              txn_req,
  output logic              txn_write,
  output logic              txn_cmd,
  output logic [ADDR_W-1:0] txn_addr,
  output logic [7:0]        txn_wdata,
  input  logic              txn_ack,
  input  logic [7:0]        txn_rdata,
  output logic              ready,
  output logic              probe_ok,
  output logic              probe_fail,
  output logic              done
);

  localparam int NREG = 7;

  typedef enum logic [2:0] {S_PW, S_PR, S_CLR, S_IDLE, S_RD, S_WR, S_HALT} st_t;

  st_t        st;
  logic [2:0] step;
  logic [7:0] wbcd [NREG];
  logic [6:0] rbin [NREG];

  function automatic logic [ADDR_W-1:0] reg_at(input logic [2:0] i);
    case (i)
      3'd0:    return A_SEC;
      3'd1:    return A_MIN;
      3'd2:    return A_HOUR;
      3'd3:    return A_MDAY;
      3'd4:    return A_MON;
      3'd5:    return A_WDAY;
      default: return A_YEAR;
    endcase
  endfunction

  function automatic logic [7:0] to_bcd(input logic [7:0] v);
    logic [7:0] r, t, u;
    r = v % 8'd100;
    t = r / 8'd10;
    u = r % 8'd10;
    return {t[3:0], u[3:0]};
  endfunction

  function automatic logic [6:0] from_bcd(input logic [7:0] b);
    return {3'b0, b[7:4]} * 7'd10 + {3'b0, b[3:0]};
  endfunction

  logic [2:0] rd_idx;
  assign rd_idx = step - 3'd1;

  always_comb begin
    txn_req   = 1'b0;
    txn_write = 1'b0;
    txn_cmd   = 1'b0;
    txn_addr  = '0;
    txn_wdata = '0;
    case (st)
      S_PW: begin
        txn_req = 1'b1; txn_write = 1'b1; txn_addr = A_SEC; txn_wdata = PROBE_PAT;
      end
      S_PR: begin
        txn_req = 1'b1; txn_addr = A_SEC;
      end
      S_CLR: begin
        txn_req = 1'b1; txn_write = 1'b1; txn_addr = A_STAT;
      end
      S_RD: begin
        txn_req = 1'b1;
        if (step == 3'd0) begin
          txn_write = 1'b1; txn_cmd = 1'b1; txn_addr = CMD_SNAP;
        end else begin
          txn_addr = reg_at(rd_idx);
        end
      end
      S_WR: begin
        txn_req = 1'b1; txn_write = 1'b1;
        if (step == 3'd7) begin
          txn_cmd = 1'b1; txn_addr = CMD_COMMIT;
        end else begin
          txn_addr  = reg_at(step);
          txn_wdata = wbcd[step];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_PW;
      step       <= '0;
      probe_ok   <= 1'b0;
      probe_fail <= 1'b0;
      done       <= 1'b0;
      for (int i = 0; i < NREG; i++) begin
        rbin[i] <= '0;
        wbcd[i] <= '0;
      end
    end else begin
      done <= 1'b0;
      case (st)
        S_PW:  if (txn_ack) st <= S_PR;
        S_PR:  if (txn_ack) begin
                 if (txn_rdata == PROBE_PAT) st <= S_CLR;
                 else begin
                   st         <= S_HALT;
                   probe_fail <= 1'b1;
                 end
               end
        S_CLR: if (txn_ack) begin
                 st       <= S_IDLE;
                 probe_ok <= 1'b1;
               end
        S_IDLE: begin
          step <= '0;
          if (rd_req) st <= S_RD;
          else if (wr_req) begin
            st      <= S_WR;
            wbcd[0] <= to_bcd({1'b0, in_sec});
            wbcd[1] <= to_bcd({1'b0, in_min});
            wbcd[2] <= to_bcd({1'b0, in_hour});
            wbcd[3] <= to_bcd({1'b0, in_mday});
            wbcd[4] <= to_bcd({1'b0, in_mon} + 8'd1);
            wbcd[5] <= to_bcd({1'b0, in_wday});
            wbcd[6] <= to_bcd(in_year);
          end
        end
        S_RD: if (txn_ack) begin
          if (step != 3'd0) rbin[rd_idx] <= from_bcd(txn_rdata);
          step <= step + 3'd1;
          if (step == 3'd7) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        S_WR: if (txn_ack) begin
          step <= step + 3'd1;
          if (step == 3'd7) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign ready    = (st == S_IDLE);
  assign out_sec  = rbin[0];
  assign out_min  = rbin[1];
  assign out_hour = rbin[2];
  assign out_mday = rbin[3];
  assign out_mon  = rbin[4] - 7'd1;
  assign out_wday = rbin[5];
  assign out_year = {1'b0, rbin[6]} + 8'd100;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    txn_req && !txn_ack |=> txn_req && $stable(txn_addr) && $stable(txn_write)
                            && $stable(txn_cmd) && $stable(txn_wdata)); // R13
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready && !txn_req); // R10
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    probe_fail |-> !txn_req && !ready && !probe_ok); // R3
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    st != S_RD |=> $stable(out_sec) && $stable(out_min) && $stable(out_hour)
                   && $stable(out_mday) && $stable(out_mon) && $stable(out_wday)
                   && $stable(out_year)); // R12
  AST_OK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    probe_ok |=> probe_ok && !probe_fail); // R2

endmodule

// File: tb/rtc_time_seq_tb.sv
`timescale 1ns/1ps
module rtc_time_seq_tb_top;
  localparam logic [3:0] A_SEC = 4'd2, A_MIN = 4'd3, A_HOUR = 4'd4, A_MDAY = 4'd5,
                         A_MON = 4'd6, A_WDAY = 4'd7, A_YEAR = 4'd8, A_STAT = 4'd0,
                         C_SNAP = 4'd14, C_COMMIT = 4'd15;

  logic clk = 0, rst_n = 0, rd_req = 0, wr_req = 0;
  logic [6:0] in_sec = 0, in_min = 0, in_hour = 0, in_mday = 0, in_mon = 0, in_wday = 0;
  logic [7:0] in_year = 0;
  logic [6:0] out_sec, out_min, out_hour, out_mday, out_mon, out_wday;
  logic [7:0] out_year;
  logic txn_req, txn_write, txn_cmd, txn_ack = 0;
  logic [3:0] txn_addr;
  logic [7:0] txn_wdata, txn_rdata = 0;
  logic ready, probe_ok, probe_fail, done;

  always #2.5 clk = ~clk;

  rtc_time_seq dut_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
    .in_sec(in_sec), .in_min(in_min), .in_hour(in_hour), .in_mday(in_mday),
    .in_mon(in_mon), .in_wday(in_wday), .in_year(in_year),
    .out_sec(out_sec), .out_min(out_min), .out_hour(out_hour), .out_mday(out_mday),
    .out_mon(out_mon), .out_wday(out_wday), .out_year(out_year),
    .txn_req(txn_req), .txn_write(txn_write), .txn_cmd(txn_cmd), .txn_addr(txn_addr),
    .txn_wdata(txn_wdata), .txn_ack(txn_ack), .txn_rdata(txn_rdata),
    .ready(ready), .probe_ok(probe_ok), .probe_fail(probe_fail), .done(done));

  int checks = 0, errors = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // device and engine model
  logic [7:0] ram [16];
  logic [7:0] clkr [16];
  bit bad_dev = 0;
  int log_n = 0;
  int lg_addr [2048];
  int lg_wr [2048];
  int lg_cmd [2048];
  int lg_data [2048];
  bit busy = 0;
  int wait_n = 0;
  int hold_err = 0;
  logic [3:0] c_addr; logic c_wr, c_cmd; logic [7:0] c_data;

  function automatic int bcd(input int v);
    return (((v % 100) / 10) << 4) | (v % 10);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      busy = 0; txn_ack = 0; log_n = 0;
    end else begin
      if (txn_ack) txn_ack = 0;
      if (busy && (txn_addr != c_addr || txn_write != c_wr || txn_cmd != c_cmd
                   || txn_wdata != c_data || !txn_req)) hold_err++;
      if (!busy && txn_req) begin
        busy = 1; wait_n = log_n % 3;
        c_addr = txn_addr; c_wr = txn_write; c_cmd = txn_cmd; c_data = txn_wdata;
      end
      if (busy) begin
        if (wait_n == 0) begin
          if (log_n < 2048) begin
            lg_addr[log_n] = c_addr; lg_wr[log_n] = c_wr;
            lg_cmd[log_n] = c_cmd; lg_data[log_n] = c_data;
          end
          log_n++;
          if (c_cmd) begin
            for (int a = 2; a <= 8; a++) begin
              if (c_addr == C_SNAP) ram[a] = clkr[a];
              if (c_addr == C_COMMIT) clkr[a] = ram[a];
            end
          end else if (c_wr) ram[c_addr] = c_data;
          else txn_rdata = (bad_dev && c_addr == A_SEC) ? ram[c_addr] ^ 8'h01 : ram[c_addr];
          txn_ack = 1; busy = 0;
        end else wait_n--;
      end
    end
  end

  task automatic run_op(input bit rd, input bit wr, output int base);
    int n;
    @(negedge clk);
    base = log_n; rd_req = rd; wr_req = wr;
    @(negedge clk);
    rd_req = 0; wr_req = 0;
    n = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
    chk(done, "R10 done seen", int'(done), 1);
    @(negedge clk);
    chk(!done && ready, "R10 done one cycle, ready after", int'({done, ready}), 1);
  endtask

  int base;
  int e [7];
  logic [6:0] h_sec, h_min, h_mon;
  logic [7:0] h_year;

  initial begin
    for (int a = 0; a < 16; a++) begin ram[a] = 8'h00; clkr[a] = 8'h00; end
    repeat (3) @(negedge clk);
    chk(!ready && !probe_ok && !probe_fail && !done, "R1 reset outputs",
        int'({ready, probe_ok, probe_fail, done}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!ready, "R1 not ready during probe", int'(ready), 0);
    for (int n = 0; n < 100 && !probe_ok && !probe_fail; n++) @(negedge clk);
    chk(probe_ok && !probe_fail && ready, "R2 probe ok", int'({probe_ok, probe_fail, ready}), 5);
    chk(log_n == 3, "R2 probe transaction count", log_n, 3);
    chk(lg_wr[0] == 1 && lg_cmd[0] == 0 && lg_addr[0] == A_SEC && lg_data[0] == 8'h33,
        "R1 probe write", lg_data[0], 8'h33);
    chk(lg_wr[1] == 0 && lg_addr[1] == A_SEC, "R1 probe read", lg_addr[1], A_SEC);
    chk(lg_wr[2] == 1 && lg_cmd[2] == 0 && lg_addr[2] == A_STAT && lg_data[2] == 0,
        "R2 status clear", lg_addr[2], A_STAT);

    // read sweep: clock registers hold values, stale RAM holds junk
    for (int k = 0; k < 60; k++) begin
      e[0] = k; e[1] = (k * 7) % 60; e[2] = k % 24; e[3] = 1 + k % 31;
      e[4] = 1 + k % 12; e[5] = k % 7; e[6] = (k * 3) % 100;
      for (int i = 0; i < 7; i++) begin clkr[2 + i] = 8'(bcd(e[i])); ram[2 + i] = 8'h99; end
      run_op(1, 0, base);
      chk(log_n - base == 8, "R5 read transaction count", log_n - base, 8);
      chk(lg_cmd[base] == 1 && lg_wr[base] == 1 && lg_addr[base] == C_SNAP,
          "R4 snapshot first", lg_addr[base], C_SNAP);
      for (int i = 0; i < 7; i++)
        chk(lg_wr[base + 1 + i] == 0 && lg_cmd[base + 1 + i] == 0 && lg_addr[base + 1 + i] == 2 + i,
            "R5 read order", lg_addr[base + 1 + i], 2 + i);
      chk(out_sec == e[0], "R6 seconds", out_sec, e[0]);
      chk(out_min == e[1], "R6 minutes", out_min, e[1]);
      chk(out_hour == e[2], "R6 hours", out_hour, e[2]);
      chk(out_mday == e[3], "R6 mday", out_mday, e[3]);
      chk(out_wday == e[5], "R6 wday", out_wday, e[5]);
      chk(out_mon == e[4] - 1, "R7 month minus one", out_mon, e[4] - 1);
      chk(out_year == e[6] + 100, "R7 year plus 100", out_year, e[6] + 100);
    end

    // set sweep; fields must stay unchanged (R12)
    h_sec = out_sec; h_min = out_min; h_mon = out_mon; h_year = out_year;
    for (int k = 0; k < 60; k++) begin
      in_sec = 7'(k); in_min = 7'((k * 11) % 60); in_hour = 7'((k * 5) % 24);
      in_mday = 7'(1 + (k * 3) % 31); in_mon = 7'(k % 12); in_wday = 7'((k * 2) % 7);
      in_year = 8'((k * 4 + 100) % 256);
      e[0] = bcd(in_sec); e[1] = bcd(in_min); e[2] = bcd(in_hour); e[3] = bcd(in_mday);
      e[4] = bcd(in_mon + 1); e[5] = bcd(in_wday); e[6] = bcd(in_year % 100);
      run_op(0, 1, base);
      chk(log_n - base == 8, "R8 set transaction count", log_n - base, 8);
      for (int i = 0; i < 7; i++)
        chk(lg_wr[base + i] == 1 && lg_cmd[base + i] == 0 && lg_addr[base + i] == 2 + i
            && lg_data[base + i] == e[i], "R8 set write", lg_data[base + i], e[i]);
      chk(lg_cmd[base + 7] == 1 && lg_addr[base + 7] == C_COMMIT, "R9 commit last",
          lg_addr[base + 7], C_COMMIT);
      chk(clkr[A_YEAR] == e[6] && clkr[A_MON] == e[4], "R9 clock loaded", clkr[A_YEAR], e[6]);
      chk(out_sec == h_sec && out_min == h_min && out_mon == h_mon && out_year == h_year,
          "R12 fields held across set", out_sec, h_sec);
    end

    // request during a running read is ignored
    @(negedge clk);
    base = log_n; rd_req = 1;
    @(negedge clk);
    rd_req = 0;
    repeat (3) @(negedge clk);
    wr_req = 1; rd_req = 1;
    @(negedge clk);
    wr_req = 0; rd_req = 0;
    for (int n = 0; n < 500 && !done; n++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(log_n - base == 8 && ready, "R10 busy request ignored", log_n - base, 8);

    // simultaneous requests: read wins
    run_op(1, 1, base);
    repeat (5) @(negedge clk);
    chk(log_n - base == 8 && lg_addr[base] == C_SNAP && lg_cmd[base] == 1,
        "R11 read wins", lg_addr[base], C_SNAP);
    chk(lg_wr[base + 1] == 0, "R11 no set performed", lg_wr[base + 1], 0);
    chk(out_year == bcd(in_year % 100) / 16 * 10 + bcd(in_year % 100) % 16 + 100,
        "R7 year after committed set", out_year, (in_year % 100) + 100);

    chk(hold_err == 0, "R13 request held stable", hold_err, 0);

    // absent device
    @(negedge clk);
    rst_n = 0; bad_dev = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int n = 0; n < 100 && !probe_fail; n++) @(negedge clk);
    chk(probe_fail && !probe_ok && !ready, "R3 probe fail", int'({probe_fail, probe_ok, ready}), 4);
    @(negedge clk);
    rd_req = 1; wr_req = 1;
    @(negedge clk);
    rd_req = 0; wr_req = 0;
    repeat (30) @(negedge clk);
    chk(log_n == 2, "R3 no further transactions", log_n, 2);
    chk(!ready && probe_fail && !done, "R3 stays halted", int'(ready), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule